// File: doc/BRIEF.md
# Tick and Alarm Timer

A free-running 32-bit counter paired with a 16-bit prescaler. Both advance once per clock while the enable input is high. Two periodic channels each watch one prescaler bit and fire when that bit rises. Two alarm channels each compare the counter against a programmed value. The counter wraps to zero after all ones, and either alarm can be set to clear the counter. Both of those raise the overflow source.

Every source sets a sticky status bit and gives a one-cycle event pulse. A combined interrupt is raised when any status bit is set and its mask bit is one. Interval selections and alarm values are written through a small register port. They only govern the counting logic after a two-cycle synchronization delay, so an event that falls inside that delay is judged against the old setting.

Status, mask and event bit order everywhere: bit 0 overflow, bit 1 periodic 0, bit 2 periodic 1, bit 3 alarm 0, bit 4 alarm 1. Register addresses: 0 control (bit n = clear-on-alarm for alarm n), 1 counter, 2 status (write one to clear), 3 prescaler (read only), 4 and 5 interval select for periodic 0 and 1 (low 4 bits), 6 and 7 alarm value 0 and 1.

Top module: `tick_alarm_timer`

## Requirements
- R1: While reset is asserted and right after it, the status, the counter, the prescaler, all event outputs and irq read zero.
- R2: When an enabled cycle moves prescaler bit S (the active interval select of periodic channel n) from 0 to 1, evt_per[n] pulses and status bit 1+n is set in the next cycle. This gives one pulse every 2^(S+1) enabled cycles.
- R3: When the counter equals the active alarm value of channel n in an enabled cycle, evt_alarm[n] pulses and status bit 3+n is set in the next cycle.
- R4: In each enabled cycle the counter increments by one. From all ones it wraps to zero, and evt_ovf pulses and status bit 0 is set.
- R5: If control bit n is one and alarm n matches, the counter becomes zero in the next cycle instead of incrementing, and evt_ovf pulses and status bit 0 is set.
- R6: irq is high exactly when some status bit is set and the int_mask bit at the same position is one. Event pulses ignore the mask.
- R7: A write to an interval select or alarm value register governs the events only from the third cycle after the write cycle. A match in the two cycles after the write uses the previous setting, so an alarm written to equal the counter value two cycles later is missed.
- R8: Status bits stay set until a one is written to the same bit of address 2. A new event in the same cycle as its clear keeps the bit set.
- R9: While en is low, the prescaler and counter hold, and no event pulses or new status bits occur.
- R10: rd_data returns the register selected by rd_addr in the same cycle. Interval select and alarm registers read back the last written value, and a counter write loads the counter at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable for prescaler and counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| int_mask | input | 5 | Interrupt mask, status bit order |
| irq | output | 1 | Combined masked interrupt |
| evt_ovf | output | 1 | Overflow event pulse |
| evt_per | output | 2 | Periodic event pulses |
| evt_alarm | output | 2 | Alarm event pulses |

## Verification
Event pulses and status bits come one edge after the enabled cycle that matches. irq and rd_data follow their inputs in the same cycle, and interval and alarm writes govern matching only from the third cycle after the write. The bench runs a cycle reference model updated at the rising edge and compares every output at the falling edge. Inputs are driven only after that comparison, so each result is sampled in the cycle it is due. Directed cases then count pulses over exact windows, for the periodic rate, the missed and the caught alarm right after a write, wrap and clear-on-alarm.

// File: rtl/tick_alarm_timer.sv
module tick_alarm_timer #(
  parameter int CNT_W    = 32,
  parameter int PRE_W    = 16,
  parameter int SEL_W    = 4,
  parameter int N_CH     = 2,
  parameter int SYNC_DLY = 2,
  parameter int AW       = $clog2(4 + 2 * N_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic [2*N_CH:0]   int_mask,
  output logic              irq,
  output logic              evt_ovf,
  output logic [N_CH-1:0]   evt_per,
  output logic [N_CH-1:0]   evt_alarm
);
  localparam int NS     = 1 + 2 * N_CH;
  localparam int A_CTRL = 0;
  localparam int A_CNT  = 1;
  localparam int A_STAT = 2;
  localparam int A_PRE  = 3;
  localparam int A_SEL  = 4;
  localparam int A_ALM  = 4 + N_CH;

  logic [PRE_W-1:0] pre_q, pre_nx;
  logic [CNT_W-1:0] cnt_q;
  logic [N_CH-1:0]  ca_q, per_hit, alm_hit;
  logic [NS-1:0]    st_q, ev_q, set_v, clr_v, keep_v;
  logic             clr_hit, wrap_hit, wr_cnt;

  logic [SEL_W-1:0] sel_sh   [N_CH];
  logic [SEL_W-1:0] sel_pipe [N_CH][SYNC_DLY];
  logic [CNT_W-1:0] alm_sh   [N_CH];
  logic [CNT_W-1:0] alm_pipe [N_CH][SYNC_DLY];

  assign pre_nx = pre_q + 1'b1;
  assign wr_cnt = wr_en && (wr_addr == AW'(A_CNT));

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign per_hit[g] = en & ~pre_q[sel_pipe[g][SYNC_DLY-1]] & pre_nx[sel_pipe[g][SYNC_DLY-1]];
    assign alm_hit[g] = en & (cnt_q == alm_pipe[g][SYNC_DLY-1]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_sh[g] <= '0;
        alm_sh[g] <= '0;
        for (int k = 0; k < SYNC_DLY; k++) begin
          sel_pipe[g][k] <= '0;
          alm_pipe[g][k] <= '0;
        end
      end else begin
        if (wr_en && wr_addr == AW'(A_SEL + g)) sel_sh[g] <= wr_data[SEL_W-1:0];
        if (wr_en && wr_addr == AW'(A_ALM + g)) alm_sh[g] <= wr_data;
        sel_pipe[g][0] <= sel_sh[g];
        alm_pipe[g][0] <= alm_sh[g];
        for (int k = 1; k < SYNC_DLY; k++) begin
          sel_pipe[g][k] <= sel_pipe[g][k-1];
          alm_pipe[g][k] <= alm_pipe[g][k-1];
        end
      end
    end
  end

  assign clr_hit  = |(alm_hit & ca_q);
  assign wrap_hit = en & (&cnt_q) & ~clr_hit;
  assign set_v    = {alm_hit, per_hit, clr_hit | wrap_hit};
  assign clr_v    = (wr_en && wr_addr == AW'(A_STAT)) ? wr_data[NS-1:0] : '0;
  assign keep_v   = st_q & ~clr_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      ca_q  <= '0;
      st_q  <= '0;
      ev_q  <= '0;
    end else begin
      if (en) pre_q <= pre_nx;
      if (wr_cnt)      cnt_q <= wr_data;
      else if (en)     cnt_q <= clr_hit ? '0 : cnt_q + 1'b1;
      if (wr_en && wr_addr == AW'(A_CTRL)) ca_q <= wr_data[N_CH-1:0];
      st_q <= keep_v | set_v;
      ev_q <= set_v;
    end
  end

  assign irq       = |(st_q & int_mask);
  assign evt_ovf   = ev_q[0];
  assign evt_per   = ev_q[N_CH:1];
  assign evt_alarm = ev_q[2*N_CH:N_CH+1];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      AW'(A_CTRL): rd_data[N_CH-1:0]  = ca_q;
      AW'(A_CNT):  rd_data            = cnt_q;
      AW'(A_STAT): rd_data[NS-1:0]    = st_q;
      AW'(A_PRE):  rd_data[PRE_W-1:0] = pre_q;
      default: ;
    endcase
    for (int i = 0; i < N_CH; i++) begin
      if (rd_addr == AW'(A_SEL + i)) rd_data[SEL_W-1:0] = sel_sh[i];
      if (rd_addr == AW'(A_ALM + i)) rd_data = alm_sh[i];
    end
  end

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_cnt) |=> ($stable(cnt_q) && $stable(pre_q)));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ev_q == '0));

  assert_wrap_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wr_cnt && (&cnt_q) && !(|(alm_hit & ca_q))) |=> (cnt_q == '0 && ev_q[0]));

  assert_clear_alarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wr_cnt && |(alm_hit & ca_q)) |=> (cnt_q == '0 && ev_q[0]));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((st_q & $past(keep_v)) == $past(keep_v)));

  assert_evt_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |-> ((ev_q & ~st_q) == '0));
endmodule

// File: tb/tick_alarm_timer_tb.sv
module tick_alarm_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [4:0]  int_mask = '0;
  logic        irq, evt_ovf;
  logic [1:0]  evt_per, evt_alarm;

  int n_chk = 0;
  int n_fail = 0;
  int wd = 0;

  always #5 clk = ~clk;

  tick_alarm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .int_mask(int_mask),
    .irq(irq), .evt_ovf(evt_ovf), .evt_per(evt_per), .evt_alarm(evt_alarm)
  );

  // reference model
  logic [15:0] m_pre;
  logic [31:0] m_cnt;
  logic [1:0]  m_ca;
  logic [4:0]  m_st, m_ev;
  logic [3:0]  m_sel [2], m_sel1 [2], m_sela [2];
  logic [31:0] m_alm [2], m_alm1 [2], m_alma [2];

  always @(posedge clk or negedge rst_n) begin
    logic [15:0] pn;
    logic [1:0]  ph, ah;
    logic        cl, wp;
    logic [4:0]  sv, cv;
    if (!rst_n) begin
      m_pre = '0; m_cnt = '0; m_ca = '0; m_st = '0; m_ev = '0;
      for (int i = 0; i < 2; i++) begin
        m_sel[i] = '0; m_sel1[i] = '0; m_sela[i] = '0;
        m_alm[i] = '0; m_alm1[i] = '0; m_alma[i] = '0;
      end
    end else begin
      pn = m_pre + 16'd1;
      for (int i = 0; i < 2; i++) begin
        ph[i] = en && !m_pre[m_sela[i]] && pn[m_sela[i]];
        ah[i] = en && (m_cnt == m_alma[i]);
      end
      cl = |(ah & m_ca);
      wp = en && (m_cnt == 32'hFFFF_FFFF) && !cl;
      sv = {ah, ph, cl | wp};
      cv = (wr_en && wr_addr == 3'd2) ? wr_data[4:0] : 5'd0;
      if (wr_en && wr_addr == 3'd1) m_cnt = wr_data;
      else if (en) m_cnt = cl ? 32'd0 : m_cnt + 32'd1;
      if (en) m_pre = pn;
      if (wr_en && wr_addr == 3'd0) m_ca = wr_data[1:0];
      m_st = (m_st & ~cv) | sv;
      m_ev = sv;
      for (int i = 0; i < 2; i++) begin
        m_sela[i] = m_sel1[i]; m_sel1[i] = m_sel[i];
        m_alma[i] = m_alm1[i]; m_alm1[i] = m_alm[i];
        if (wr_en && wr_addr == 3'(4 + i)) m_sel[i] = wr_data[3:0];
        if (wr_en && wr_addr == 3'(6 + i)) m_alm[i] = wr_data;
      end
    end
  end

  function automatic logic [31:0] m_rd(input logic [2:0] a);
    case (a)
      3'd0: return {30'd0, m_ca};
      3'd1: return m_cnt;
      3'd2: return {27'd0, m_st};
      3'd3: return {16'd0, m_pre};
      3'd4: return {28'd0, m_sel[0]};
      3'd5: return {28'd0, m_sel[1]};
      3'd6: return m_alm[0];
      default: return m_alm[1];
    endcase
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk("R4 evt_ovf", {31'd0, evt_ovf}, {31'd0, m_ev[0]});
    chk("R2 evt_per", {30'd0, evt_per}, {30'd0, m_ev[2:1]});
    chk("R3 evt_alarm", {30'd0, evt_alarm}, {30'd0, m_ev[4:3]});
    chk("R6 irq", {31'd0, irq}, {31'd0, |(m_st & int_mask)});
    chk("R10 rd_data", rd_data, m_rd(rd_addr));
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", wd);
      summary();
      $finish;
    end
  end

  initial begin
    int cnt_p0, cnt_p1, cnt_a;
    logic [31:0] snap;
    void'($urandom(32'd7301));
    int_mask = 5'h1F;

    // R1: reset state
    rd_addr = 3'd2;
    repeat (3) cyc();
    chk("R1 status", rd_data, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 events", {27'd0, evt_alarm, evt_per, evt_ovf}, 32'd0);
    rst_n = 1'b1;
    rd_addr = 3'd1;
    cyc();
    chk("R1 counter", rd_data, 32'd0);

    // setup while disabled
    wr(3'd6, 32'd1000);
    wr(3'd7, 32'd2000);
    wr(3'd4, 32'd2);
    wr(3'd5, 32'd5);
    repeat (3) cyc();
    en = 1'b1;

    // R2: rate 2^(S+1)
    cnt_p0 = 0; cnt_p1 = 0;
    for (int i = 0; i < 64; i++) begin
      cyc();
      if (evt_per[0]) cnt_p0++;
      if (evt_per[1]) cnt_p1++;
    end
    chk("R2 per0 pulses in 64", cnt_p0, 32'd8);
    chk("R2 per1 pulses in 64", cnt_p1, 32'd1);

    // R7: alarm two cycles after write is missed
    wr(3'd6, m_cnt + 32'd2);
    cnt_a = 0;
    for (int i = 0; i < 10; i++) begin cyc(); if (evt_alarm[0]) cnt_a++; end
    chk("R7 missed alarm", cnt_a, 32'd0);
    // R7/R3: three cycles after write is caught
    wr(3'd6, m_cnt + 32'd3);
    cnt_a = 0;
    for (int i = 0; i < 10; i++) begin cyc(); if (evt_alarm[0]) cnt_a++; end
    chk("R7 caught alarm", cnt_a, 32'd1);

    // R5: clear on alarm 1
    wr(3'd0, 32'd2);
    wr(3'd7, m_cnt + 32'd10);
    rd_addr = 3'd1;
    for (int i = 0; i < 30; i++) begin
      cyc();
      if (evt_alarm[1]) begin
        chk("R5 counter cleared", rd_data, 32'd0);
        chk("R5 ovf pulse", {31'd0, evt_ovf}, 32'd1);
        break;
      end
    end
    chk("R5 status ovf", {31'd0, m_st[0]}, 32'd1);
    wr(3'd0, 32'd0);

    // R4: wrap
    wr(3'd1, 32'hFFFF_FFFD);
    chk("R4 counter loaded", rd_data, 32'hFFFF_FFFD);
    repeat (3) cyc();
    chk("R4 wrap to zero", rd_data, 32'd0);
    chk("R4 wrap ovf pulse", {31'd0, evt_ovf}, 32'd1);

    // R9: hold while disabled
    en = 1'b0;
    cyc();
    snap = rd_data;
    cnt_a = 0;
    for (int i = 0; i < 12; i++) begin
      cyc();
      if (evt_ovf || evt_per != 0 || evt_alarm != 0) cnt_a++;
    end
    chk("R9 counter held", rd_data, snap);
    chk("R9 no events", cnt_a, 32'd0);

    // R8: write-one-to-clear, sticky
    rd_addr = 3'd2;
    cyc();
    snap = rd_data;
    chk("R8 ovf sticky", {31'd0, rd_data[0]}, 32'd1);
    wr(3'd2, 32'd1);
    chk("R8 clear bit0 only", rd_data, snap & 32'h1E);
    // R6: mask gating
    int_mask = 5'h01;
    cyc();
    chk("R6 irq masked off", {31'd0, irq}, 32'd0);
    int_mask = 5'h1E;
    cyc();
    chk("R6 irq unmasked", {31'd0, irq}, {31'd0, |snap[4:1]});
    wr(3'd2, 32'h1F);
    chk("R8 all cleared", rd_data, 32'd0);
    chk("R6 irq after clear", {31'd0, irq}, 32'd0);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      en = ($urandom % 8) != 0;
      int_mask = 5'($urandom);
      rd_addr = 3'($urandom);
      if (($urandom % 4) == 0) begin
        wr_en = 1'b1;
        wr_addr = 3'($urandom);
        case (wr_addr)
          3'd1: wr_data = (($urandom % 2) != 0) ? 32'hFFFF_FFF0 + ($urandom % 16) : $urandom % 200;
          3'd6, 3'd7: wr_data = m_cnt + ($urandom % 24);
          default: wr_data = $urandom;
        endcase
      end else begin
        wr_en = 1'b0;
      end
      cyc();
    end
    wr_en = 1'b0;
    cyc();
    summary();
    $finish;
  end
endmodule